// File: doc/BRIEF.md
# NAND Command and Address Front-End

This block is the device-side interface logic of a small-page NAND memory. Software on the host side drives a byte-wide bus together with two latch enables and two strobes: write enable and read enable, both active low. Both strobes are brought into the system clock domain, and their edges are found there. On each rising write-enable edge the byte on the bus is sorted into a command, an address or a data byte. Commands are decoded into one-cycle requests (read, program, erase, reset) for the array controller that sits behind this block.

Three address cycles fill a column pointer and a page number. The read command that came before the address picks the column region the pointer starts in: the lower half of the main area, the upper half, or the spare bytes. Each falling read-enable edge moves the column pointer on by one. At the last column the pointer rolls into the next page and a new array read is requested. A status command switches the output bus to a status byte, and an identify command switches it to two identification bytes. Otherwise the bus carries the array data byte at the current column.

Top module: `nand_front_end`

## Requirements
- R1: On a rising write-enable edge, the byte is a command when `cle_i`=1 and `ale_i`=0, an address when `ale_i`=1 and `cle_i`=0, and a data byte when both are 0. A data byte raises `din_we_o` for one cycle.
- R2: Address cycle 1 loads the column. Cycle 2 loads page bits 7:0. Cycle 3 loads page bits 12:8 from `io_i[4:0]`. Any further address cycle leaves both column and page unchanged.
- R3: Command 00h starts the column at the address byte. Command 01h starts it at 256 plus the byte. Command 50h starts it at 512 plus `io_i[3:0]`, and `io_i[7:4]` is ignored.
- R4: The spare region chosen by 50h stays in force across later commands until 00h or FFh. The 01h region applies only to the page being loaded, so a rollover from it starts the next page at column 0.
- R5: In array output mode, each falling read-enable edge adds one to the column. At the last column (527, or 511 when `short_page_i`=1) the edge instead sets the column to the region start (512 in the spare region, else 0), adds one to the page and pulses `read_req_o`.
- R6: The third address cycle after 00h, 01h or 50h pulses `read_req_o` once.
- R7: After 70h, `io_o` reads {`wp_ni`, not `busy_i`, 5'b0, `fail_i`}. Command 00h returns the bus to array data.
- R8: After 90h, `io_o` reads 98h. After one falling read-enable edge it reads E5h and holds it. The column does not move in this mode.
- R9: 10h pulses `prog_req_o` only when the command accepted just before it was 80h. Any other command accepted in between cancels the program.
- R10: D0h pulses `erase_req_o` only when it directly follows 60h. After 60h, two address cycles load page bits 7:0 and then 12:8.
- R11: FFh pulses `reset_req_o`, clears column and page to 0, selects the low region and returns the bus to array data.
- R12: While `busy_i`=1, only FFh and 70h are acted on. Other commands, address bytes and data bytes are ignored.
- R13: A command byte outside {00,01,10,50,60,70,80,90,D0,FF}h pulses `illegal_cmd_o` and changes no state.
- R14: Each data byte adds one to the column, and the column stops at the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, active low, asynchronous |
| re_ni | input | 1 | Read strobe, active low, asynchronous |
| io_i | input | 8 | Byte bus into the block |
| wp_ni | input | 1 | Write protect, 0 = protected |
| busy_i | input | 1 | Array operation in progress |
| fail_i | input | 1 | Result of last program/erase, 1 = fail |
| short_page_i | input | 1 | 1 = 512-byte pages, no spare area |
| array_dout_i | input | 8 | Array byte at the current column |
| io_o | output | 8 | Byte bus out of the block |
| col_o | output | 10 | Current column pointer |
| page_o | output | 13 | Current page number |
| din_we_o | output | 1 | Data byte on `io_i` to be written at `col_o` |
| read_req_o | output | 1 | Request an array-to-register page transfer |
| prog_req_o | output | 1 | Request a page program |
| erase_req_o | output | 1 | Request a block erase |
| reset_req_o | output | 1 | Request an abort/reset of the array operation |
| illegal_cmd_o | output | 1 | Unknown command byte seen |

## Verification
A wrong region register shows up on `col_o` at the first address cycle after the next command. That is about three clocks after the write-enable rise, when the base 256 or 512 is missing or extra. A wrong pending-program or pending-erase flag appears as a missing or extra request pulse in the cycle after the confirming command. A column counter that is off by one only shows itself as a rollover that comes early or late. For that reason the tests drive long read bursts right up to the last column and check the page and the request count at the crossing. A wrong output-mode state is visible on `io_o` at once, without any strobe.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  typedef enum logic [1:0] {RGN_LOW = 2'd0, RGN_HIGH = 2'd1, RGN_SPARE = 2'd2} region_e;
  typedef enum logic [1:0] {OUT_ARRAY = 2'd0, OUT_STATUS = 2'd1, OUT_ID = 2'd2} outsel_e;

  localparam logic [7:0] OP_READ_LO     = 8'h00;
  localparam logic [7:0] OP_READ_HI     = 8'h01;
  localparam logic [7:0] OP_READ_SP     = 8'h50;
  localparam logic [7:0] OP_LOAD        = 8'h80;
  localparam logic [7:0] OP_PROG        = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_IDENT       = 8'h90;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  localparam logic [7:0] ID_MAKER  = 8'h98;
  localparam logic [7:0] ID_DEVICE = 8'hE5;
endpackage

// File: rtl/nfe_strobe_sync.sv
module nfe_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R1
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nfe_cmd_decode.sv
module nfe_cmd_decode
  import nfe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_stb_i,
  input  logic [7:0] cmd_i,
  input  logic       busy_i,
  input  logic       id_step_i,
  output logic       acc_o,
  output outsel_e    out_sel_o,
  output logic       read_armed_o,
  output logic       id_second_o,
  output logic       prog_req_o,
  output logic       erase_req_o,
  output logic       reset_req_o,
  output logic       illegal_o
);
  logic    known, take;
  logic    prog_pend_q, erase_pend_q, read_armed_q, id_second_q;
  outsel_e out_sel_q;

  always_comb begin
    known = cmd_i inside {OP_READ_LO, OP_READ_HI, OP_READ_SP, OP_LOAD, OP_PROG,
                          OP_ERASE_SETUP, OP_ERASE_GO, OP_STATUS, OP_IDENT, OP_RESET};
    // busy filter: only reset and status pass
    take  = cmd_stb_i & (~busy_i | (cmd_i == OP_RESET) | (cmd_i == OP_STATUS));
    acc_o = take & known;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_pend_q  <= 1'b0;
      erase_pend_q <= 1'b0;
      read_armed_q <= 1'b0;
      id_second_q  <= 1'b0;
      out_sel_q    <= OUT_ARRAY;
      prog_req_o   <= 1'b0;
      erase_req_o  <= 1'b0;
      reset_req_o  <= 1'b0;
      illegal_o    <= 1'b0;
    end else begin
      prog_req_o  <= 1'b0;
      erase_req_o <= 1'b0;
      reset_req_o <= 1'b0;
      illegal_o   <= take & ~known;
      if (acc_o) begin
        prog_pend_q  <= (cmd_i == OP_LOAD);
        erase_pend_q <= (cmd_i == OP_ERASE_SETUP);
        prog_req_o   <= (cmd_i == OP_PROG) & prog_pend_q;
        erase_req_o  <= (cmd_i == OP_ERASE_GO) & erase_pend_q;
        reset_req_o  <= (cmd_i == OP_RESET);
        read_armed_q <= cmd_i inside {OP_READ_LO, OP_READ_HI, OP_READ_SP};
        case (cmd_i)
          OP_READ_LO, OP_READ_HI, OP_READ_SP, OP_RESET: out_sel_q <= OUT_ARRAY;
          OP_STATUS: out_sel_q <= OUT_STATUS;
          OP_IDENT:  out_sel_q <= OUT_ID;
          default:   ;
        endcase
        if (cmd_i == OP_IDENT) id_second_q <= 1'b0;
      end else if (id_step_i && out_sel_q == OUT_ID) begin
        id_second_q <= 1'b1;
      end
    end
  end

  assign out_sel_o    = out_sel_q;
  assign read_armed_o = read_armed_q;
  assign id_second_o  = id_second_q;

  // R12
  busy_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && busy_i && cmd_i != OP_RESET && cmd_i != OP_STATUS)
      |=> $stable(out_sel_q) && !illegal_o && !prog_req_o && !erase_req_o);
  // R13
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !prog_req_o && !erase_req_o && !reset_req_o && $stable(out_sel_q));
endmodule

// File: rtl/nfe_addr_ctrl.sv
module nfe_addr_ctrl
  import nfe_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int COL_W       = 10,
  parameter int PAGE_W      = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_acc_i,
  input  logic [7:0]        cmd_i,
  input  logic              addr_stb_i,
  input  logic              din_stb_i,
  input  logic              rd_step_i,
  input  logic [7:0]        io_i,
  input  logic              read_armed_i,
  input  logic              busy_i,
  input  logic              short_page_i,
  output logic [COL_W-1:0]  col_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              read_req_o
);
  localparam int LAST_FULL = MAIN_BYTES + SPARE_BYTES - 1;
  localparam int LAST_MAIN = MAIN_BYTES - 1;
  localparam int HALF      = MAIN_BYTES / 2;
  localparam int SPARE_W   = $clog2(SPARE_BYTES);
  localparam int PAGE_HI_W = PAGE_W - 8;

  logic [1:0]        acnt_q;
  logic [COL_W-1:0]  col_q, load_col, last_col, wrap_col;
  logic [PAGE_W-1:0] page_q;
  region_e           region_q;

  always_comb begin
    last_col = short_page_i ? COL_W'(LAST_MAIN) : COL_W'(LAST_FULL);
    wrap_col = (region_q == RGN_SPARE) ? COL_W'(MAIN_BYTES) : '0;
    case (region_q)
      RGN_HIGH:  load_col = COL_W'(HALF) + COL_W'(io_i);
      RGN_SPARE: load_col = COL_W'(MAIN_BYTES) + COL_W'(io_i[SPARE_W-1:0]);
      default:   load_col = COL_W'(io_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q     <= '0;
      col_q      <= '0;
      page_q     <= '0;
      region_q   <= RGN_LOW;
      read_req_o <= 1'b0;
    end else begin
      read_req_o <= 1'b0;
      if (cmd_acc_i) begin
        // erase address carries no column byte
        acnt_q <= (cmd_i == OP_ERASE_SETUP) ? 2'd1 : 2'd0;
        case (cmd_i)
          OP_READ_LO: region_q <= RGN_LOW;
          OP_READ_HI: region_q <= RGN_HIGH;
          OP_READ_SP: region_q <= RGN_SPARE;
          OP_RESET: begin
            region_q <= RGN_LOW;
            col_q    <= '0;
            page_q   <= '0;
          end
          default: ;
        endcase
      end else if (addr_stb_i && !busy_i) begin
        if (acnt_q != 2'd3) acnt_q <= acnt_q + 2'd1;
        case (acnt_q)
          2'd0: begin
            col_q <= load_col;
            if (region_q == RGN_HIGH) region_q <= RGN_LOW;  // one page only
          end
          2'd1: page_q[7:0] <= io_i;
          2'd2: begin
            page_q[PAGE_W-1:8] <= io_i[PAGE_HI_W-1:0];
            read_req_o         <= read_armed_i;
          end
          default: ;
        endcase
      end else if (din_stb_i && !busy_i) begin
        if (col_q != last_col) col_q <= col_q + 1'b1;
      end else if (rd_step_i && !busy_i) begin
        if (col_q == last_col) begin
          col_q      <= wrap_col;
          page_q     <= page_q + 1'b1;
          read_req_o <= 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign col_o  = col_q;
  assign page_o = page_q;

  // R5
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_step_i && !busy_i && !cmd_acc_i && !addr_stb_i && !din_stb_i && col_q != last_col)
      |=> col_q == $past(col_q) + 1'b1);
  // R5
  wrap_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_step_i && !busy_i && !cmd_acc_i && !addr_stb_i && !din_stb_i && col_q == last_col)
      |=> read_req_o && page_q == $past(page_q) + 1'b1);
  // R3
  spare_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_stb_i && !busy_i && !cmd_acc_i && acnt_q == 2'd0 && region_q == RGN_SPARE)
      |=> col_q >= COL_W'(MAIN_BYTES) && col_q <= COL_W'(LAST_FULL));
  // R2
  extra_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_stb_i && !cmd_acc_i && acnt_q == 2'd3) |=> $stable(col_q) && $stable(page_q));
endmodule

// File: rtl/nand_front_end.sv
module nand_front_end
  import nfe_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int PAGE_W      = 13,
  parameter int SYNC_STAGES = 2,
  parameter int COL_W       = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic              we_ni,
  input  logic              re_ni,
  input  logic [7:0]        io_i,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              fail_i,
  input  logic              short_page_i,
  input  logic [7:0]        array_dout_i,
  output logic [7:0]        io_o,
  output logic [COL_W-1:0]  col_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              din_we_o,
  output logic              read_req_o,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic              reset_req_o,
  output logic              illegal_cmd_o
);
  localparam int N_STB = 2;  // 0: write strobe, 1: read strobe

  logic [N_STB-1:0] stb_n, stb_rise, stb_fall;
  assign stb_n = {re_ni, we_ni};

  for (genvar g = 0; g < N_STB; g++) begin : g_sync
    nfe_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_ni(stb_n[g]),
      .rise_o   (stb_rise[g]),
      .fall_o   (stb_fall[g])
    );
  end

  logic    cmd_stb, addr_stb, din_stb, rd_step;
  logic    cmd_acc, read_armed, id_second;
  outsel_e out_sel;

  assign cmd_stb  = stb_rise[0] &  cle_i & ~ale_i;
  assign addr_stb = stb_rise[0] & ~cle_i &  ale_i;
  assign din_stb  = stb_rise[0] & ~cle_i & ~ale_i;
  assign rd_step  = stb_fall[1] & (out_sel == OUT_ARRAY);
  assign din_we_o = din_stb & ~busy_i;

  nfe_cmd_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_stb_i   (cmd_stb),
    .cmd_i       (io_i),
    .busy_i      (busy_i),
    .id_step_i   (stb_fall[1]),
    .acc_o       (cmd_acc),
    .out_sel_o   (out_sel),
    .read_armed_o(read_armed),
    .id_second_o (id_second),
    .prog_req_o  (prog_req_o),
    .erase_req_o (erase_req_o),
    .reset_req_o (reset_req_o),
    .illegal_o   (illegal_cmd_o)
  );

  nfe_addr_ctrl #(
    .MAIN_BYTES (MAIN_BYTES),
    .SPARE_BYTES(SPARE_BYTES),
    .COL_W      (COL_W),
    .PAGE_W     (PAGE_W)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_acc_i   (cmd_acc),
    .cmd_i       (io_i),
    .addr_stb_i  (addr_stb),
    .din_stb_i   (din_stb),
    .rd_step_i   (rd_step),
    .io_i        (io_i),
    .read_armed_i(read_armed),
    .busy_i      (busy_i),
    .short_page_i(short_page_i),
    .col_o       (col_o),
    .page_o      (page_o),
    .read_req_o  (read_req_o)
  );

  always_comb begin
    case (out_sel)
      OUT_STATUS: io_o = {wp_ni, ~busy_i, 5'b0, fail_i};
      OUT_ID:     io_o = id_second ? ID_DEVICE : ID_MAKER;
      default:    io_o = array_dout_i;
    endcase
  end

  // R6, R9, R10, R11
  one_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({read_req_o, prog_req_o, erase_req_o, reset_req_o}));
  // R8
  id_hold_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_fall[1] && out_sel == OUT_ID && !stb_rise[0]) |=> $stable(col_o));
endmodule

// File: tb/nand_front_end_test.sv
module nand_front_end_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0]  io = 8'h00;
  logic        wp_n = 1'b1, busy = 1'b0, fail = 1'b0, short_page = 1'b0;
  logic [7:0]  arr_dout, io_out;
  logic [9:0]  col;
  logic [12:0] page;
  logic        din_we, rd_req, pg_req, er_req, rs_req, ill;

  int n_chk = 0, n_err = 0;
  int n_rd = 0, n_pg = 0, n_er = 0, n_rs = 0, n_ill = 0, n_din = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign arr_dout = col[7:0] ^ page[7:0];

  nand_front_end uut (
    .clk_i(clk), .rst_ni(rst_n), .cle_i(cle), .ale_i(ale), .we_ni(we_n), .re_ni(re_n),
    .io_i(io), .wp_ni(wp_n), .busy_i(busy), .fail_i(fail), .short_page_i(short_page),
    .array_dout_i(arr_dout), .io_o(io_out), .col_o(col), .page_o(page),
    .din_we_o(din_we), .read_req_o(rd_req), .prog_req_o(pg_req), .erase_req_o(er_req),
    .reset_req_o(rs_req), .illegal_cmd_o(ill)
  );

  always @(posedge clk) begin
    n_rd  <= n_rd  + int'(rd_req);
    n_pg  <= n_pg  + int'(pg_req);
    n_er  <= n_er  + int'(er_req);
    n_rs  <= n_rs  + int'(rs_req);
    n_ill <= n_ill + int'(ill);
    n_din <= n_din + int'(din_we);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; io = b; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
  task automatic din(input logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); re_n = 1'b0;
      repeat (3) @(negedge clk);
      re_n = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    check("R11 reset col", int'(col), 0);
    check("R11 reset page", int'(page), 0);
    check("R1 reset bus", int'(io_out), 0);
    check("R6 no request", n_rd + n_pg + n_er + n_rs + n_ill, 0);
  endtask

  task automatic t_low_read();
    int r0 = n_rd;
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h05);
    check("R2 column", int'(col), 'h12);
    check("R2 page", int'(page), 'h534);
    check("R6 read request", n_rd - r0, 1);
    check("R1 array byte", int'(io_out), 'h12 ^ 'h34);
    adr(8'h77);
    check("R2 fourth col", int'(col), 'h12);
    check("R2 fourth page", int'(page), 'h534);
    check("R6 no extra request", n_rd - r0, 1);
  endtask

  task automatic t_high_read_wrap();
    int r0 = n_rd;
    cmd(8'h01); adr(8'h20); adr(8'h01); adr(8'h00);
    check("R3 high base", int'(col), 'h120);
    cmd(8'h01); adr(8'hFE); adr(8'h02); adr(8'h00);
    check("R3 high base 2", int'(col), 510);
    rd(17);
    check("R5 step to last", int'(col), 527);
    check("R5 no early wrap", int'(page), 2);
    rd(1);
    check("R4 high wraps to 0", int'(col), 0);
    check("R5 page advance", int'(page), 3);
    check("R5 wrap request", n_rd - r0, 3);
  endtask

  task automatic t_spare();
    int p0 = n_pg, d0 = n_din;
    cmd(8'h50); adr(8'hF7); adr(8'h05); adr(8'h00);
    check("R3 spare ignores high nibble", int'(col), 519);
    rd(8);
    check("R5 spare last", int'(col), 527);
    rd(1);
    check("R5 spare wrap col", int'(col), 512);
    check("R5 spare wrap page", int'(page), 6);
    cmd(8'h80); adr(8'h03); adr(8'h07); adr(8'h00);
    check("R4 spare persists", int'(col), 515);
    din(8'hA1); din(8'hA2); din(8'hA3);
    check("R1 data strobes", n_din - d0, 3);
    check("R14 data advances col", int'(col), 518);
    cmd(8'h10);
    check("R9 program request", n_pg - p0, 1);
    cmd(8'h80); adr(8'h0E); adr(8'h00); adr(8'h00);
    check("R4 spare still", int'(col), 526);
    din(8'h01); din(8'h02); din(8'h03);
    check("R14 data stops at last", int'(col), 527);
    cmd(8'h00);
    cmd(8'h10);
    check("R9 cancelled program", n_pg - p0, 1);
    adr(8'h03); adr(8'h00); adr(8'h00);
    check("R4 00h leaves spare", int'(col), 3);
  endtask

  task automatic t_short_page();
    int r0 = n_rd;
    short_page = 1'b1;
    cmd(8'h01); adr(8'hFE); adr(8'h00); adr(8'h00);
    rd(1);
    check("R5 short last", int'(col), 511);
    rd(1);
    check("R5 short wrap col", int'(col), 0);
    check("R5 short wrap page", int'(page), 1);
    check("R5 short requests", n_rd - r0, 2);
    short_page = 1'b0;
  endtask

  task automatic t_status_busy();
    int r0 = n_rd, s0 = n_rs, c0;
    cmd(8'h70);
    wp_n = 1'b1; fail = 1'b1; busy = 1'b0; #1;
    check("R7 status ready fail", int'(io_out), 'hC1);
    wp_n = 1'b0; fail = 1'b0; busy = 1'b1; #1;
    check("R7 status busy protected", int'(io_out), 'h00);
    wp_n = 1'b1;
    c0 = int'(col);
    cmd(8'h00);
    check("R12 00h ignored while busy", int'(io_out), 'h80);
    adr(8'h55);
    check("R12 address ignored while busy", int'(col), c0);
    check("R12 no read while busy", n_rd - r0, 0);
    cmd(8'hFF);
    check("R11 reset while busy", n_rs - s0, 1);
    check("R11 reset col", int'(col), 0);
    check("R11 reset page", int'(page), 0);
    check("R11 bus back to array", int'(io_out), 0);
    busy = 1'b0;
    cmd(8'h70);
    cmd(8'h00);
    check("R7 00h leaves status", int'(io_out), 0);
  endtask

  task automatic t_ident();
    int c0;
    cmd(8'h00); adr(8'h21); adr(8'h00); adr(8'h00);
    c0 = int'(col);
    cmd(8'h90); adr(8'h00);
    check("R8 first id", int'(io_out), 'h98);
    rd(1);
    check("R8 second id", int'(io_out), 'hE5);
    rd(1);
    check("R8 id holds", int'(io_out), 'hE5);
    check("R8 col still", int'(col), 0);
    c0 = c0;
  endtask

  task automatic t_erase();
    int e0 = n_er, r0 = n_rd;
    cmd(8'h60); adr(8'h45); adr(8'h03);
    check("R10 erase page", int'(page), 'h345);
    cmd(8'hD0);
    check("R10 erase request", n_er - e0, 1);
    check("R10 no read", n_rd - r0, 0);
    cmd(8'h60); cmd(8'h70); cmd(8'hD0);
    check("R10 erase broken", n_er - e0, 1);
  endtask

  task automatic t_illegal();
    int i0 = n_ill, p0;
    cmd(8'h00); adr(8'h44); adr(8'h00); adr(8'h00);
    p0 = n_rd;
    cmd(8'h33);
    check("R13 illegal flagged", n_ill - i0, 1);
    check("R13 col unchanged", int'(col), 'h44);
    check("R13 no request", n_rd - p0, 0);
    rd(1);
    check("R13 mode unchanged", int'(col), 'h45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_low_read();
    t_high_read_wrap();
    t_spare();
    t_short_page();
    t_status_busy();
    t_ident();
    t_erase();
    t_illegal();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule